// File: doc/BRIEF.md
# Sub-Cycle Event Edge Timestamper

This block assigns a fine-grained arrival time to a single asynchronous event edge. An external high-rate deserializer samples the event line at one sample per ns or faster and hands over a word of successive samples on every core clock. The block runs a free-running coarse cycle counter. It locates the earliest low-to-high transition in the sample stream, including a transition that straddles two words. It then appends the position of that transition inside the word to the coarse count, so the time resolution is one sample period rather than one core cycle.

A programmable calibration value is subtracted from the assembled time to remove the fixed input path delay. The result is held in a latch with a valid flag until a slow host acknowledges it. Edges that arrive while the latch is full are not captured. An overrun flag records that at least one was missed.

Top module: `ts_edge_stamp`

## Requirements
- R1: While rst_ni is low, valid_o and overrun_o are 0 and the coarse counter is 0. The stored previous sample is taken as 1, so a line that is already high when reset is released is not an edge.
- R2: The coarse counter has COARSE_W bits. It counts 0 in the first core cycle after reset release, increments by one each cycle, and wraps modulo 2^COARSE_W.
- R3: Sample bit 0 of sample_word_i is the oldest sample. A rise is at index i when sample i is 1 and the sample before it is 0. The candidate time is coarse_count*SAMPLE_W + i for the lowest such i, computed modulo 2^TS_W.
- R4: The sample before bit 0 is bit SAMPLE_W-1 of the previous word. A previous word ending in 0 followed by a word with bit 0 set gives index 0.
- R5: The stored stamp equals the candidate time minus offset_i, modulo 2^TS_W, with offset_i taken in the capture cycle.
- R6: A rise seen while the latch is empty is stored at that clock edge, and valid_o is 1 from the next cycle. While valid_o is 1 and ack_i is low, valid_o stays 1 and stamp_o is unchanged.
- R7: A rise seen while valid_o is 1 and ack_i is low does not change stamp_o, and it sets overrun_o.
- R8: ack_i high clears valid_o and overrun_o. A rise in the same cycle as ack_i is stored as a new capture, leaving valid_o 1 and overrun_o 0.
- R9: A word with no rise (all zeros, all ones, or only falling transitions) changes neither valid_o nor stamp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_word_i | input | SAMPLE_W | Deserialized event samples, oldest in bit 0 |
| offset_i | input | TS_W | Calibration delay subtracted from each stamp |
| ack_i | input | 1 | Host read acknowledge, one-cycle pulse |
| stamp_o | output | TS_W | Latched timestamp |
| valid_o | output | 1 | Latch holds an unread stamp |
| overrun_o | output | 1 | An edge was missed while the latch was full |

## Verification
Every result is due one core cycle after its stimulus. A word and ack presented before clock edge k update valid_o, overrun_o and stamp_o at edge k, and the stamp carries the counter value k counted from reset release. The bench drives inputs on the falling edge, counts rising edges itself to know the coarse value in use, and compares all outputs at the following falling edge. It runs in a small configuration with a 6-bit counter, so wrap-around and every word value with both boundary histories are covered.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_CAPTURE = 2'd1,
    ACT_CLEAR   = 2'd2,
    ACT_MISS    = 2'd3
  } cap_act_e;
endpackage

// File: rtl/ts_coarse_cnt.sv
module ts_coarse_cnt #(
  parameter int unsigned COARSE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [COARSE_W-1:0] cnt_o
);
  logic [COARSE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == COARSE_W'($past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/ts_edge_find.sv
module ts_edge_find #(
  parameter int unsigned SAMPLE_W = 8,
  localparam int unsigned IDX_W = $clog2(SAMPLE_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic                last_q;
  logic [SAMPLE_W:0]   ext;
  logic [SAMPLE_W-1:0] rise;

  // previous word's newest sample, high after reset to block a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= word_i[SAMPLE_W-1];
  end

  assign ext = {word_i, last_q};

  for (genvar g = 0; g < SAMPLE_W; g++) begin : g_rise
    assign rise[g] = ~ext[g] & ext[g+1];
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = SAMPLE_W - 1; i >= 0; i--) begin
      if (rise[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  AST_FIRST_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rise[idx_o] && ((rise & ~({SAMPLE_W{1'b1}} << idx_o)) == '0)); // R3
  AST_WORD_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_q && word_i[0]) |-> (hit_o && idx_o == '0)); // R4
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_pkg::*;
#(
  parameter int unsigned TS_W = 35
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            ack_i,
  input  logic [TS_W-1:0] cand_i,
  output logic [TS_W-1:0] stamp_o,
  output logic            valid_o,
  output logic            overrun_o
);
  cap_act_e        act;
  logic [TS_W-1:0] stamp_q;
  logic            valid_q, ovr_q;

  // slot counts as free in the ack cycle
  always_comb begin
    if (hit_i && (!valid_q || ack_i)) act = ACT_CAPTURE;
    else if (ack_i)                   act = ACT_CLEAR;
    else if (hit_i)                   act = ACT_MISS;
    else                              act = ACT_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      unique case (act)
        ACT_CAPTURE: begin
          stamp_q <= cand_i;
          valid_q <= 1'b1;
          ovr_q   <= 1'b0;
        end
        ACT_CLEAR: begin
          valid_q <= 1'b0;
          ovr_q   <= 1'b0;
        end
        ACT_MISS: ovr_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign stamp_o   = stamp_q;
  assign valid_o   = valid_q;
  assign overrun_o = ovr_q;

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ack_i) |=> valid_q); // R6
  AST_STAMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ack_i) |=> $stable(stamp_q)); // R7
  AST_CAPTURE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !valid_q) |=> (valid_q && !ovr_q)); // R6
  AST_MISS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && valid_q && !ack_i) |=> ovr_q); // R7
  AST_OVR_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> valid_q); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit_i) |=> (!valid_q && !ovr_q)); // R8
endmodule

// File: rtl/ts_edge_stamp.sv
module ts_edge_stamp #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned COARSE_W = 32,
  localparam int unsigned IDX_W = $clog2(SAMPLE_W),
  localparam int unsigned TS_W  = COARSE_W + IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_word_i,
  input  logic [TS_W-1:0]     offset_i,
  input  logic                ack_i,
  output logic [TS_W-1:0]     stamp_o,
  output logic                valid_o,
  output logic                overrun_o
);
  logic [COARSE_W-1:0] cnt;
  logic                hit;
  logic [IDX_W-1:0]    idx;
  logic [TS_W-1:0]     cand;

  ts_coarse_cnt #(.COARSE_W(COARSE_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  ts_edge_find #(.SAMPLE_W(SAMPLE_W)) u_find (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .word_i(sample_word_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  // SAMPLE_W is a power of two, so count*SAMPLE_W + idx is a concatenation
  assign cand = {cnt, idx} - offset_i;

  ts_capture #(.TS_W(TS_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .ack_i    (ack_i),
    .cand_i   (cand),
    .stamp_o  (stamp_o),
    .valid_o  (valid_o),
    .overrun_o(overrun_o)
  );

  AST_SAMPLE_POW2: assert final ((1 << IDX_W) == SAMPLE_W); // R3
endmodule

// File: tb/sim_ts_edge_stamp.sv
`timescale 1ns/1ps
module sim_ts_edge_stamp;
  localparam int SW = 8;
  localparam int CW = 6;
  localparam int TW = CW + 3;
  localparam int CMOD = 1 << CW;
  localparam int TMOD = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW-1:0] word = '0;
  logic [TW-1:0] off = '0;
  logic          ack = 1'b0;
  logic [TW-1:0] stamp;
  logic          valid, ovr;

  int checks = 0, failures = 0, cyc = 0;
  bit mv = 0, mo = 0, mp = 1;
  int mts = 0;

  always #5 clk = ~clk;

  ts_edge_stamp #(.SAMPLE_W(SW), .COARSE_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_word_i(word), .offset_i(off),
    .ack_i(ack), .stamp_o(stamp), .valid_o(valid), .overrun_o(ovr)
  );

  function automatic bit find_rise(input logic [7:0] w, input bit p, output int idx);
    idx = 0;
    for (int i = 0; i < 8; i++) begin
      bit lo;
      lo = (i == 0) ? p : w[i-1];
      if (!lo && w[i]) begin idx = i; return 1; end
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [7:0] w, input bit a, input string tag);
    int idx;
    bit f;
    int st;
    f  = find_rise(w, mp, idx);
    st = (((cyc % CMOD) * SW + idx - int'(off)) % TMOD + TMOD) % TMOD;
    if (f && (!mv || a)) begin mv = 1; mo = 0; mts = st; end
    else if (a) begin mv = 0; mo = 0; end
    else if (f && mv) mo = 1;
    mp = w[7];
    word = w;
    ack  = a;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    chk(tag, "valid", int'(valid), int'(mv));
    chk(tag, "overrun", int'(ovr), int'(mo));
    if (mv) chk(tag, "stamp", int'(stamp), mts);
  endtask

  initial begin
    #(100000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk("R1", "valid", int'(valid), 0);
    chk("R1", "overrun", int'(ovr), 0);
    rst_ni = 1'b1;
    // line already high at release: no edge
    step(8'hFF, 0, "R1");
    step(8'hFF, 0, "R9");
    step(8'hF0, 0, "R9");

    // sweep every word after a low and a high history
    for (int w = 0; w < 256; w++) begin
      for (int p = 0; p < 2; p++) begin
        string tag;
        bit pb;
        off = TW'((w * 37 + p * 11) % TMOD);
        step(p ? 8'hFF : 8'h00, 1, "R8");
        pb = mp;
        if (!find_rise(8'(w), pb, d))      tag = "R9";
        else if (!pb && w[0])              tag = "R4";
        else                               tag = "R3";
        step(8'(w), 0, tag);
      end
    end

    // offsets
    for (int k = 0; k < 24; k++) begin
      off = TW'((k * 29) % TMOD);
      step(8'h00, 1, "R8");
      step(8'h08, 0, "R5");
    end
    off = '0;

    // every counter value through wrap
    for (int k = 0; k < 2 * CMOD + 3; k++) begin
      step(8'h00, 1, "R8");
      step(8'h01, 0, "R2");
    end

    // hold, overrun, ack
    step(8'h00, 1, "R8");
    step(8'h3C, 0, "R6");
    step(8'h00, 0, "R6");
    step(8'h01, 0, "R7");
    step(8'h80, 0, "R7");
    step(8'hFF, 0, "R6");
    step(8'h00, 1, "R8");
    step(8'h06, 0, "R6");
    step(8'h00, 0, "R7");
    step(8'h10, 0, "R7");
    step(8'h02, 1, "R8");
    step(8'h00, 0, "R6");
    step(8'h00, 1, "R8");
    step(8'h00, 0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule